// File: doc/BRIEF.md
# External SRAM Bus Controller

This block sits between an on-chip memory request port and an asynchronous static RAM bus. A requester presents an address, a direction and write data. It holds the request until the controller raises `req_ready` for one cycle. The controller checks the address against four chip-select windows. Each window has its own base, its own power-of-two size, an enable mode and a wait-state count. For the first enabled window that matches, the controller runs one bus access. It asserts that window's active-low select, shows the address, and drives an active-low read or write strobe for the programmed length.

The address can be driven flat on 24 lines. It can also be time-shared over the low byte lanes `bus_addr[7:0]` using one or two latch-enable phases, so that external latches can capture the upper address bytes. The data bus is split into an output, an output enable and an input. The bidirectional pad sits outside the block. Only the 8-bit data width is supported.

A request that matches no window, or that arrives while the width setting is not 8-bit, completes at once with an error flag.

Top module: `ext_sram_bus_ctrl`

## Requirements
- R1: `bus_cs_n` has four active-low lines, and at most one is low at any time. The selected line stays low for the whole access, through the latch and strobe phases. All four lines are high when no access is running.
- R2: Window k matches when the request address and `{base_k, 12'h000}` agree on every bit from max(12, 8+n) up to 23, where n is the 5-bit size code. Code n means 256·2^n bytes. Because bits 11:0 are never compared, windows smaller than 4 KB behave as 4 KB. Codes of 16 and above cover the whole 16 MB space.
- R3: A window takes part in decoding only when its 2-bit mode is 01. Modes 00, 10 and 11 leave it disabled.
- R4: When several enabled windows match, the window with the lowest index is selected.
- R5: A request that is accepted but matches no enabled window asserts no select and no strobe. In the cycle after acceptance it raises `req_ready` and `req_err` together for one cycle, with `req_rdata` = 0.
- R6: The strobe stays low for (wait + 1) cycles, where wait is the 3-bit count of the selected window. `req_ready` is high for exactly one cycle, in the cycle that follows the last strobe cycle.
- R7: With address mode 11, `bus_addr` carries the full request address for the whole access and is 0 when idle.
- R8: Address modes 00, 01 and 10 add one, one and two latch phases before the strobe. Each phase lasts one clock, with `bus_ale[0]` high in the first phase and `bus_ale[1]` high in the second. The strobe starts in the clock right after the last phase.
  - The lane `bus_addr[7:0]` carries the following bytes during the latch phases: byte 1 in mode 00, byte 2 in mode 01, and byte 1 then byte 2 in mode 10. During the strobe it carries byte 0.
  - Bytes that are not multiplexed are driven on their own lanes: byte 2 on `bus_addr[23:16]` in mode 00, and byte 1 on `bus_addr[15:8]` in mode 01.
  - All other address bits are 0.
- R9: The bus width code 01 selects 8-bit data. With any other code, every request is rejected as in R5.
- R10: During a write, `bus_wr_n` is low and `bus_oe` is high in exactly the strobe cycles, and `bus_dout` holds the write data. During a read, `bus_rd_n` is low and `bus_oe` stays low.
- R11: For a read, `req_rdata` is the value on `bus_din` in the last strobe cycle. Values in earlier strobe cycles are ignored.
- R12: Only one request is in flight at a time. A request still held high during the `req_ready` cycle is not accepted a second time. After reset the bus is idle: selects and strobes high, latch enables low, address 0, output enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Request byte address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Completion had no matching window or a bad width |
| req_rdata | output | 8 | Read data, valid with `req_ready` |
| cfg_base | input | 48 | Four 12-bit window bases (address bits 23:12), window k at [12k+11:12k] |
| cfg_size | input | 20 | Four 5-bit size codes, window k at [5k+4:5k] |
| cfg_mode | input | 8 | Four 2-bit modes, window k at [2k+1:2k] |
| cfg_wait | input | 12 | Four 3-bit wait counts, window k at [3k+2:3k] |
| cfg_addr_mode | input | 2 | Address multiplexing mode (R7, R8) |
| cfg_bus_width | input | 2 | Data width code; 01 = 8 bits |
| bus_cs_n | output | 4 | Active-low chip selects |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_ale | output | 2 | Latch enables for the first and second latch phase |
| bus_addr | output | 24 | External address lines |
| bus_dout | output | 8 | Data driven to the bus |
| bus_oe | output | 1 | Data output enable for the pad |
| bus_din | input | 8 | Data read from the bus |

## Verification
The bench probes the edges of the windows: the last byte of a 512 KB window, the first byte past a 4 KB window, and a size code of zero that still decodes as 4 KB. A decoder that compared too many or too few address bits would select the wrong window or miss entirely. The bench also overlaps a 16 MB window with smaller windows to expose a priority encoder that favours the higher index. It turns windows off with codes 10 and 11 to catch a mode check that only tests one bit.

Each multiplexed mode is checked byte by byte on every cycle. This catches a swapped lane, a missing second latch phase or a strobe that overlaps a latch enable. During reads, `bus_din` carries a wrong value except in the last strobe cycle, so a controller that samples early returns corrupt data. Wait counts of 0, 1, 4 and 7 show off-by-one strobe lengths. Holding the request through the ready cycle shows whether the controller accepts the same request twice.

// File: rtl/sram_bus_pkg.sv
package sram_bus_pkg;

    localparam int BYTE_W = 8;

    // Address multiplexing mode; the encoding is decoded by the sequencer
    typedef enum logic [1:0] {
        AM_MUX_B1  = 2'b00,   // byte 1 shares the low lane, one latch phase
        AM_MUX_B2  = 2'b01,   // byte 2 shares the low lane, one latch phase
        AM_MUX_B12 = 2'b10,   // bytes 1 then 2 share the low lane, two phases
        AM_FLAT    = 2'b11    // full address, no latch phase
    } addr_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LATCH,
        ST_STROBE
    } seq_state_e;

    localparam logic [1:0] CS_MODE_SRAM = 2'b01;
    localparam logic [1:0] BUS_WIDTH_8  = 2'b01;

    function automatic logic has_second_latch(addr_mode_e m);
        return m == AM_MUX_B12;
    endfunction

endpackage

// File: rtl/sram_region_match.sv
module sram_region_match
    import sram_bus_pkg::*;
#(
    parameter int ADDR_W    = 24,
    parameter int BASE_LSB  = 12,
    parameter int SIZE_W    = 5,
    parameter int SIZE_LSB0 = 8
) (
    input  logic [ADDR_W-BASE_LSB-1:0] addr_hi,
    input  logic [ADDR_W-BASE_LSB-1:0] base,
    input  logic [SIZE_W-1:0]          size_code,
    input  logic [1:0]                 mode,
    output logic                       hit
);
    localparam int BASE_W = ADDR_W - BASE_LSB;

    logic [BASE_W-1:0] care;

    // An address bit takes part in the compare when it lies above the window span
    always_comb begin
        for (int i = 0; i < BASE_W; i++) begin
            care[i] = (int'(size_code) + SIZE_LSB0) <= (i + BASE_LSB);
        end
    end

    assign hit = (mode == CS_MODE_SRAM) && (((addr_hi ^ base) & care) == '0);

endmodule

// File: rtl/sram_region_decode.sv
module sram_region_decode
    import sram_bus_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int ADDR_W   = 24,
    parameter int BASE_LSB = 12,
    parameter int SIZE_W   = 5,
    parameter int WAIT_W   = 3
) (
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [NUM_CS*(ADDR_W-BASE_LSB)-1:0] cfg_base,
    input  logic [NUM_CS*SIZE_W-1:0]            cfg_size,
    input  logic [NUM_CS*2-1:0]                 cfg_mode,
    input  logic [NUM_CS*WAIT_W-1:0]            cfg_wait,
    output logic                                hit_any,
    output logic [NUM_CS-1:0]                   sel,
    output logic [WAIT_W-1:0]                   sel_wait
);
    localparam int BASE_W = ADDR_W - BASE_LSB;

    logic [NUM_CS-1:0] hits;

    for (genvar k = 0; k < NUM_CS; k++) begin : g_win
        sram_region_match #(
            .ADDR_W   (ADDR_W),
            .BASE_LSB (BASE_LSB),
            .SIZE_W   (SIZE_W),
            .SIZE_LSB0(8)
        ) u_match (
            .addr_hi  (addr[ADDR_W-1:BASE_LSB]),
            .base     (cfg_base[k*BASE_W +: BASE_W]),
            .size_code(cfg_size[k*SIZE_W +: SIZE_W]),
            .mode     (cfg_mode[k*2 +: 2]),
            .hit      (hits[k])
        );
    end

    // Lowest index wins
    always_comb begin
        hit_any  = 1'b0;
        sel      = '0;
        sel_wait = '0;
        for (int k = 0; k < NUM_CS; k++) begin
            if (hits[k] && !hit_any) begin
                hit_any  = 1'b1;
                sel[k]   = 1'b1;
                sel_wait = cfg_wait[k*WAIT_W +: WAIT_W];
            end
        end
    end

endmodule

// File: rtl/sram_access_seq.sv
module sram_access_seq
    import sram_bus_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_we,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                dec_hit,
    input  logic [NUM_CS-1:0]   dec_sel,
    input  logic [WAIT_W-1:0]   dec_wait,
    input  logic [1:0]          cfg_addr_mode,
    input  logic                width_ok,
    input  logic [DATA_W-1:0]   bus_din,
    output logic                req_ready,
    output logic                req_err,
    output logic [DATA_W-1:0]   req_rdata,
    output logic [NUM_CS-1:0]   bus_cs_n,
    output logic                bus_rd_n,
    output logic                bus_wr_n,
    output logic [1:0]          bus_ale,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W-1:0]   bus_dout,
    output logic                bus_oe
);
    seq_state_e          state_q;
    addr_mode_e          mode_q;
    logic                phase_q;
    logic [WAIT_W-1:0]   wait_q;
    logic                we_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [NUM_CS-1:0]   cs_q;
    logic                ready_q;
    logic                err_q;
    logic [DATA_W-1:0]   rdata_q;

    logic                accept;
    addr_mode_e          mode_in;

    assign mode_in = addr_mode_e'(cfg_addr_mode);
    assign accept  = req_valid && !ready_q && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= AM_FLAT;
            phase_q <= 1'b0;
            wait_q  <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            cs_q    <= '0;
            ready_q <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ready_q <= 1'b0;
            err_q   <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (dec_hit && width_ok) begin
                            we_q    <= req_we;
                            addr_q  <= req_addr;
                            wdata_q <= req_wdata;
                            cs_q    <= dec_sel;
                            wait_q  <= dec_wait;
                            mode_q  <= mode_in;
                            phase_q <= 1'b0;
                            state_q <= (mode_in == AM_FLAT) ? ST_STROBE : ST_LATCH;
                        end else begin
                            ready_q <= 1'b1;
                            err_q   <= 1'b1;
                            rdata_q <= '0;
                        end
                    end
                end
                ST_LATCH: begin
                    if (has_second_latch(mode_q) && !phase_q) begin
                        phase_q <= 1'b1;
                    end else begin
                        state_q <= ST_STROBE;
                    end
                end
                ST_STROBE: begin
                    if (wait_q == '0) begin
                        ready_q <= 1'b1;
                        state_q <= ST_IDLE;
                        if (!we_q) begin
                            rdata_q <= bus_din;
                        end
                    end else begin
                        wait_q <= wait_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Address lane construction
    logic [BYTE_W-1:0] byte0, byte1, byte2, lane;
    logic [ADDR_W-1:0] mux_addr;
    logic              busy;

    assign byte0 = addr_q[0 +: BYTE_W];
    assign byte1 = addr_q[BYTE_W +: BYTE_W];
    assign byte2 = addr_q[2*BYTE_W +: BYTE_W];
    assign busy  = (state_q != ST_IDLE);

    always_comb begin
        lane = byte0;
        if (state_q == ST_LATCH) begin
            case (mode_q)
                AM_MUX_B1:  lane = byte1;
                AM_MUX_B2:  lane = byte2;
                AM_MUX_B12: lane = phase_q ? byte2 : byte1;
                default:    lane = byte0;
            endcase
        end
        mux_addr = '0;
        mux_addr[0 +: BYTE_W] = lane;
        if (mode_q == AM_MUX_B1) begin
            mux_addr[2*BYTE_W +: BYTE_W] = byte2;
        end else if (mode_q == AM_MUX_B2) begin
            mux_addr[BYTE_W +: BYTE_W] = byte1;
        end
    end

    always_comb begin
        bus_cs_n = busy ? ~cs_q : '1;
        bus_rd_n = !((state_q == ST_STROBE) && !we_q);
        bus_wr_n = !((state_q == ST_STROBE) && we_q);
        bus_oe   = (state_q == ST_STROBE) && we_q;
        bus_dout = bus_oe ? wdata_q : '0;
        bus_ale  = 2'b00;
        if (state_q == ST_LATCH) begin
            bus_ale = phase_q ? 2'b10 : 2'b01;
        end
        if (!busy) begin
            bus_addr = '0;
        end else if (mode_q == AM_FLAT) begin
            bus_addr = addr_q;
        end else begin
            bus_addr = mux_addr;
        end
    end

    assign req_ready = ready_q;
    assign req_err   = err_q;
    assign req_rdata = rdata_q;

endmodule

// File: rtl/ext_sram_bus_ctrl.sv
module ext_sram_bus_ctrl
    import sram_bus_pkg::*;
#(
    parameter int NUM_CS   = 4,
    parameter int ADDR_W   = 24,
    parameter int DATA_W   = 8,
    parameter int BASE_LSB = 12,
    parameter int SIZE_W   = 5,
    parameter int WAIT_W   = 3
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                req_valid,
    input  logic                                req_we,
    input  logic [ADDR_W-1:0]                   req_addr,
    input  logic [DATA_W-1:0]                   req_wdata,
    output logic                                req_ready,
    output logic                                req_err,
    output logic [DATA_W-1:0]                   req_rdata,
    input  logic [NUM_CS*(ADDR_W-BASE_LSB)-1:0] cfg_base,
    input  logic [NUM_CS*SIZE_W-1:0]            cfg_size,
    input  logic [NUM_CS*2-1:0]                 cfg_mode,
    input  logic [NUM_CS*WAIT_W-1:0]            cfg_wait,
    input  logic [1:0]                          cfg_addr_mode,
    input  logic [1:0]                          cfg_bus_width,
    output logic [NUM_CS-1:0]                   bus_cs_n,
    output logic                                bus_rd_n,
    output logic                                bus_wr_n,
    output logic [1:0]                          bus_ale,
    output logic [ADDR_W-1:0]                   bus_addr,
    output logic [DATA_W-1:0]                   bus_dout,
    output logic                                bus_oe,
    input  logic [DATA_W-1:0]                   bus_din
);
    logic              dec_hit;
    logic [NUM_CS-1:0] dec_sel;
    logic [WAIT_W-1:0] dec_wait;
    logic              width_ok;

    assign width_ok = (cfg_bus_width == BUS_WIDTH_8);

    sram_region_decode #(
        .NUM_CS  (NUM_CS),
        .ADDR_W  (ADDR_W),
        .BASE_LSB(BASE_LSB),
        .SIZE_W  (SIZE_W),
        .WAIT_W  (WAIT_W)
    ) u_decode (
        .addr    (req_addr),
        .cfg_base(cfg_base),
        .cfg_size(cfg_size),
        .cfg_mode(cfg_mode),
        .cfg_wait(cfg_wait),
        .hit_any (dec_hit),
        .sel     (dec_sel),
        .sel_wait(dec_wait)
    );

    sram_access_seq #(
        .NUM_CS(NUM_CS),
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .WAIT_W(WAIT_W)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_we       (req_we),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .dec_hit      (dec_hit),
        .dec_sel      (dec_sel),
        .dec_wait     (dec_wait),
        .cfg_addr_mode(cfg_addr_mode),
        .width_ok     (width_ok),
        .bus_din      (bus_din),
        .req_ready    (req_ready),
        .req_err      (req_err),
        .req_rdata    (req_rdata),
        .bus_cs_n     (bus_cs_n),
        .bus_rd_n     (bus_rd_n),
        .bus_wr_n     (bus_wr_n),
        .bus_ale      (bus_ale),
        .bus_addr     (bus_addr),
        .bus_dout     (bus_dout),
        .bus_oe       (bus_oe)
    );

endmodule

// File: rtl/ext_sram_bus_checks.sv
module ext_sram_bus_checks #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              req_err,
    input logic [NUM_CS-1:0] bus_cs_n,
    input logic              bus_rd_n,
    input logic              bus_wr_n,
    input logic [1:0]        bus_ale,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_oe
);
    p_cs_single_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    p_err_no_select_r5: assert property (@(posedge clk) disable iff (rst)
        req_err |-> (req_ready && (&bus_cs_n)));

    p_ready_one_cycle_r6: assert property (@(posedge clk) disable iff (rst)
        req_ready |=> !req_ready);

    p_addr_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (!(&bus_cs_n) && !$past(&bus_cs_n) && (bus_ale == 2'b00) && ($past(bus_ale) == 2'b00))
        |-> $stable(bus_addr));

    p_ale_no_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        (|bus_ale) |-> (bus_rd_n && bus_wr_n && !(&bus_cs_n)));

    p_strobe_follows_ale_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(|bus_ale) |-> (!bus_rd_n || !bus_wr_n));

    p_strobes_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    p_oe_with_write_r10: assert property (@(posedge clk) disable iff (rst)
        bus_oe == !bus_wr_n);

    p_wdata_steady_r10: assert property (@(posedge clk) disable iff (rst)
        (!bus_wr_n && !$past(bus_wr_n)) |-> $stable(bus_dout));

    p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (&bus_cs_n) |-> (bus_rd_n && bus_wr_n && (bus_ale == 2'b00) && !bus_oe));

endmodule

bind ext_sram_bus_ctrl ext_sram_bus_checks #(
    .NUM_CS(NUM_CS),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_checks (
    .clk      (clk),
    .rst      (rst),
    .req_ready(req_ready),
    .req_err  (req_err),
    .bus_cs_n (bus_cs_n),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_ale  (bus_ale),
    .bus_addr (bus_addr),
    .bus_dout (bus_dout),
    .bus_oe   (bus_oe)
);

// File: tb/tb_ext_sram_bus_ctrl.sv
module tb_ext_sram_bus_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [23:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, req_err;
    logic [7:0]  req_rdata;
    logic [47:0] cfg_base = '0;
    logic [19:0] cfg_size = '0;
    logic [7:0]  cfg_mode = '0;
    logic [11:0] cfg_wait = '0;
    logic [1:0]  cfg_addr_mode = 2'b11;
    logic [1:0]  cfg_bus_width = 2'b01;
    logic [3:0]  bus_cs_n;
    logic        bus_rd_n, bus_wr_n, bus_oe;
    logic [1:0]  bus_ale;
    logic [23:0] bus_addr;
    logic [7:0]  bus_dout;
    logic [7:0]  bus_din = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_sram_bus_ctrl dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_err(req_err), .req_rdata(req_rdata),
        .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_mode(cfg_mode), .cfg_wait(cfg_wait),
        .cfg_addr_mode(cfg_addr_mode), .cfg_bus_width(cfg_bus_width),
        .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_ale(bus_ale),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
    );

    typedef struct {
        logic [3:0]  cs_n;
        logic        rd_n;
        logic        wr_n;
        logic [1:0]  ale;
        logic [23:0] addr;
        logic        oe;
        logic [7:0]  dout;
        logic        ready;
        logic        err;
        logic        chk_rd;
        logic [7:0]  rdata;
        logic [7:0]  din;
        string       tag;
    } cyc_exp_t;

    cyc_exp_t exp_q[$];
    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;

    function automatic cyc_exp_t idle_exp(string tag);
        cyc_exp_t e;
        e.cs_n = 4'hF; e.rd_n = 1'b1; e.wr_n = 1'b1; e.ale = 2'b00; e.addr = 24'h0;
        e.oe = 1'b0; e.dout = 8'h00; e.ready = 1'b0; e.err = 1'b0; e.chk_rd = 1'b0;
        e.rdata = 8'h00; e.din = 8'h5A; e.tag = tag;
        return e;
    endfunction

    // Expected bus address; ph 0 = strobe, 1 = first latch, 2 = second latch
    function automatic logic [23:0] model_addr(logic [1:0] am, logic [23:0] a, int ph);
        logic [7:0] lane;
        if (ph == 0)       lane = a[7:0];
        else if (am == 0)  lane = a[15:8];
        else if (am == 1)  lane = a[23:16];
        else               lane = (ph == 1) ? a[15:8] : a[23:16];
        case (am)
            2'd3:    return a;
            2'd0:    return {a[23:16], 8'h00, lane};
            2'd1:    return {8'h00, a[15:8], lane};
            default: return {16'h0000, lane};
        endcase
    endfunction

    function automatic int pick_window(logic [23:0] a);
        for (int r = 0; r < 4; r++) begin
            int sh;
            int unsigned wa, wb;
            if (cfg_mode[r*2 +: 2] != 2'b01) continue;
            sh = int'(cfg_size[r*5 +: 5]) + 8;
            if (sh < 12) sh = 12;
            if (sh >= 24) return r;
            wa = int'(a) >> sh;
            wb = (int'(cfg_base[r*12 +: 12]) << 12) >> sh;
            if (wa == wb) return r;
        end
        return -1;
    endfunction

    task automatic check(string tag, string field, logic [31:0] act, logic [31:0] expv);
        compared++;
        if (act !== expv) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", tag, field, act, expv, cycles);
        end
    endtask

    // Reference comparison on every falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            cyc_exp_t e;
            if (exp_q.size() > 0) e = exp_q.pop_front();
            else e = idle_exp("R12");
            check(e.tag, "cs_n", 32'(bus_cs_n), 32'(e.cs_n));
            check(e.tag, "rd_n", 32'(bus_rd_n), 32'(e.rd_n));
            check(e.tag, "wr_n", 32'(bus_wr_n), 32'(e.wr_n));
            check(e.tag, "ale", 32'(bus_ale), 32'(e.ale));
            check(e.tag, "addr", 32'(bus_addr), 32'(e.addr));
            check(e.tag, "oe", 32'(bus_oe), 32'(e.oe));
            if (e.oe) check(e.tag, "dout", 32'(bus_dout), 32'(e.dout));
            check(e.tag, "ready", 32'(req_ready), 32'(e.ready));
            check(e.tag, "err", 32'(req_err), 32'(e.err));
            if (e.chk_rd) check(e.tag, "rdata", 32'(req_rdata), 32'(e.rdata));
            bus_din = e.din;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000) begin
            mismatched++;
            $display("FAIL R12 watchdog: actual still running, expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic do_req(string tag, logic we, logic [23:0] a, logic [7:0] wd);
        int r, nph, w, len;
        cyc_exp_t e;
        logic [7:0] good;
        @(posedge clk); #1;
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        good = a[7:0] ^ a[15:8] ^ 8'hA5;
        len = 0;
        exp_q.push_back(idle_exp(tag)); len++;
        r = pick_window(a);
        if (r < 0 || cfg_bus_width != 2'b01) begin
            e = idle_exp(tag);
            e.ready = 1'b1; e.err = 1'b1; e.chk_rd = 1'b1; e.rdata = 8'h00;
            exp_q.push_back(e); len++;
        end else begin
            nph = (cfg_addr_mode == 2'b11) ? 0 : ((cfg_addr_mode == 2'b10) ? 2 : 1);
            w = int'(cfg_wait[r*3 +: 3]);
            for (int p = 1; p <= nph; p++) begin
                e = idle_exp(tag);
                e.cs_n = ~(4'b0001 << r);
                e.ale = (p == 1) ? 2'b01 : 2'b10;
                e.addr = model_addr(cfg_addr_mode, a, p);
                exp_q.push_back(e); len++;
            end
            for (int s = 0; s <= w; s++) begin
                e = idle_exp(tag);
                e.cs_n = ~(4'b0001 << r);
                e.rd_n = we; e.wr_n = !we; e.oe = we; e.dout = wd;
                e.addr = model_addr(cfg_addr_mode, a, 0);
                e.din = (s == w) ? good : ~good;
                exp_q.push_back(e); len++;
            end
            e = idle_exp(tag);
            e.ready = 1'b1; e.chk_rd = !we; e.rdata = good;
            exp_q.push_back(e); len++;
        end
        repeat (len - 1) @(posedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic set_win(int r, logic [11:0] base, logic [4:0] sz, logic [1:0] md, logic [2:0] wt);
        @(posedge clk); #1;
        cfg_base[r*12 +: 12] = base;
        cfg_size[r*5 +: 5]   = sz;
        cfg_mode[r*2 +: 2]   = md;
        cfg_wait[r*3 +: 3]   = wt;
    endtask

    initial begin
        set_win(0, 12'h100, 5'd11, 2'b01, 3'd4);  // 512 KB at 0x100000
        set_win(1, 12'h180, 5'd4,  2'b01, 3'd0);  // 4 KB at 0x180000
        set_win(2, 12'h200, 5'd0,  2'b01, 3'd1);  // code 0 -> 4 KB at 0x200000
        set_win(3, 12'h300, 5'd16, 2'b10, 3'd7);  // disabled (mode 10)
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // flat address mode
        do_req("R7",  1'b0, 24'h100040, 8'h00);
        do_req("R10", 1'b1, 24'h17FFFF, 8'h5C);
        do_req("R1",  1'b0, 24'h180010, 8'h00);
        do_req("R2",  1'b0, 24'h181000, 8'h00);
        do_req("R2",  1'b0, 24'h200FFF, 8'h00);
        do_req("R5",  1'b1, 24'h400000, 8'h77);
        do_req("R3",  1'b0, 24'h300000, 8'h00);
        set_win(2, 12'h200, 5'd0, 2'b11, 3'd1);
        do_req("R3",  1'b0, 24'h200010, 8'h00);
        set_win(2, 12'h200, 5'd0, 2'b01, 3'd1);
        do_req("R6",  1'b1, 24'h200020, 8'h91);
        do_req("R11", 1'b0, 24'h1000FF, 8'h00);
        do_req("R12", 1'b0, 24'h200000, 8'h00);

        // multiplexed address modes
        @(posedge clk); #1 cfg_addr_mode = 2'b00;
        do_req("R8", 1'b0, 24'h12ABCD, 8'h00);
        do_req("R8", 1'b1, 24'h1345EF, 8'h3E);
        @(posedge clk); #1 cfg_addr_mode = 2'b01;
        do_req("R8", 1'b0, 24'h156789, 8'h00);
        @(posedge clk); #1 cfg_addr_mode = 2'b10;
        do_req("R8", 1'b1, 24'h16A1B2, 8'hC4);
        do_req("R8", 1'b0, 24'h17C3D4, 8'h00);

        // unsupported data width codes
        @(posedge clk); #1 cfg_addr_mode = 2'b11; cfg_bus_width = 2'b00;
        do_req("R9", 1'b0, 24'h100000, 8'h00);
        @(posedge clk); #1 cfg_bus_width = 2'b10;
        do_req("R9", 1'b1, 24'h100001, 8'h12);
        @(posedge clk); #1 cfg_bus_width = 2'b01;

        // 16 MB window overlapping the others
        set_win(3, 12'h300, 5'd16, 2'b01, 3'd7);
        do_req("R4", 1'b0, 24'h180004, 8'h00);
        do_req("R4", 1'b0, 24'h100004, 8'h00);
        do_req("R6", 1'b0, 24'h500000, 8'h00);
        do_req("R2", 1'b1, 24'hFFFFFF, 8'hE1);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule